// File: doc/BRIEF.md
# Edge-Triggered Line Interrupt Controller

This block watches sixteen interrupt lines, each fed from one of several general-purpose pin ports. A per-line port selector decides which port drives a line, and line n always takes pin n of the chosen port. The selected pin first passes through a two-flop synchronizer. An edge detector then compares the synchronized level with its value one cycle earlier. Software chooses for each line whether rising edges, falling edges, both or neither count as triggers.

A trigger has two independently masked effects. If the line's interrupt mask bit is set, the trigger sets the line's pending bit, and the interrupt request output follows that bit until software clears it by writing 1 to it. If the line's event mask bit is set, the trigger produces a one-cycle pulse on the line's event output. The event path never touches the pending state.

All configuration sits behind a small word-addressed register port with single-cycle writes and a combinational read. A selector index that names no existing port ties the line low. After reset nothing is enabled.

Top module: `edge_irq_ctrl`

## Requirements
- R1: After reset every register reads 0, no interrupt request is raised and no event pulse is produced.
- R2: Selector registers sit at addresses 0 to 3. Line n takes its 4-bit port index from address n/4, bits 4*(n mod 4) to 4*(n mod 4)+3. Port p pin n is input bit p*16+n. A line responds only to pin n of its selected port; the same pin of any other port has no effect.
- R3: A selector index of NUM_PORTS or more holds the line at a constant low level, so no pin change on any port triggers it.
- R4: With only the rising-trigger bit set (address 6, bit n), a low-to-high change on the selected pin sets pending on the third rising clock edge after the change, and a high-to-low change sets nothing.
- R5: With only the falling-trigger bit set (address 7, bit n), a high-to-low change sets pending after the same three edges, and a low-to-high change sets nothing.
- R6: With both trigger bits set, either edge triggers the line. With neither bit set, no edge triggers it.
- R7: A trigger sets the pending bit only when the interrupt mask bit (address 4, bit n) is 1.
- R8: When the event mask bit (address 5, bit n) is 1, a trigger drives event output n high for exactly one cycle, in the cycle in which pending would be set, and leaves the pending bit unchanged.
- R9: Interrupt request n is high exactly while pending bit n is set, and pending reads back at address 8.
- R10: Writing to address 8 clears each pending bit written with 1 and leaves each bit written with 0 unchanged. Writes to other addresses never clear pending.
- R11: If a trigger and a write-1 clear of the same line fall in the same cycle, the pending bit stays set.
- R12: The mask, trigger-enable and selector registers read back the last value written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pins_i | input | NUM_PORTS*16 | Pin levels, port p pin n at bit p*16+n |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register word address |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data for reg_addr_i (combinational) |
| irq_o | output | 16 | Interrupt request per line (pending state) |
| evt_o | output | 16 | One-cycle event pulse per line |

## Verification
Two operations can act on the same pending bit in the same clock edge: a new trigger that sets it and a software write that clears it. The bench provokes this collision by first making a line pending. It then raises that line's pin again and times the write-1 strobe so that the strobe is active on exactly the third rising edge after the pin change, which is the edge that latches the trigger. The result is judged by sampling the request output after that edge and requiring it to be high. A control case clears the same bit with no edge present and requires the output to drop.

// File: rtl/eirq_pkg.sv
package eirq_pkg;
  localparam int LINES          = 16;
  localparam int SEL_W          = 4;
  localparam int FIELDS_PER_REG = 4;
  localparam int DATA_W         = FIELDS_PER_REG * SEL_W;
  localparam int SEL_REGS       = LINES / FIELDS_PER_REG;
  localparam int SEL_IDX_W      = $clog2(SEL_REGS);
  localparam int ADDR_W         = 4;

  localparam logic [ADDR_W-1:0] ADDR_IMASK = 4'd4;
  localparam logic [ADDR_W-1:0] ADDR_EMASK = 4'd5;
  localparam logic [ADDR_W-1:0] ADDR_RISE  = 4'd6;
  localparam logic [ADDR_W-1:0] ADDR_FALL  = 4'd7;
  localparam logic [ADDR_W-1:0] ADDR_PEND  = 4'd8;
endpackage

// File: rtl/eirq_line_front.sv
module eirq_line_front
  import eirq_pkg::*;
#(
  parameter int NUM_PORTS   = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_PORTS-1:0] pins_i,
  input  logic [SEL_W-1:0]     sel_i,
  input  logic                 rise_en_i,
  input  logic                 fall_en_i,
  output logic                 trig_o
);
  logic                   raw;
  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic                   prev_q, prev_d;
  logic                   level;

  // port mux: an index naming no port leaves the line low
  always_comb begin
    raw = 1'b0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (sel_i == SEL_W'(p)) raw = pins_i[p];
    end
  end

  always_comb begin
    sync_d = {sync_q[SYNC_STAGES-2:0], raw};
    prev_d = sync_q[SYNC_STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  assign level  = sync_q[SYNC_STAGES-1];
  assign trig_o = (rise_en_i & level & ~prev_q) | (fall_en_i & ~level & prev_q);
endmodule

// File: rtl/eirq_regfile.sv
module eirq_regfile
  import eirq_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_i,
  input  logic [ADDR_W-1:0]      addr_i,
  input  logic [DATA_W-1:0]      wdata_i,
  input  logic [LINES-1:0]       pend_i,
  output logic [LINES*SEL_W-1:0] sel_o,
  output logic [LINES-1:0]       imask_o,
  output logic [LINES-1:0]       emask_o,
  output logic [LINES-1:0]       rise_o,
  output logic [LINES-1:0]       fall_o,
  output logic [LINES-1:0]       pend_clr_o,
  output logic [DATA_W-1:0]      rdata_o
);
  logic [SEL_REGS-1:0][DATA_W-1:0] sel_q;
  logic [DATA_W-1:0] imask_q, emask_q, rise_q, fall_q;
  logic [SEL_REGS-1:0] sel_we;
  logic imask_we, emask_we, rise_we, fall_we, pend_we;

  // write decode
  always_comb begin
    for (int i = 0; i < SEL_REGS; i++) begin
      sel_we[i] = wr_i && (addr_i == ADDR_W'(i));
    end
    imask_we = wr_i && (addr_i == ADDR_IMASK);
    emask_we = wr_i && (addr_i == ADDR_EMASK);
    rise_we  = wr_i && (addr_i == ADDR_RISE);
    fall_we  = wr_i && (addr_i == ADDR_FALL);
    pend_we  = wr_i && (addr_i == ADDR_PEND);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q   <= '0;
      imask_q <= '0;
      emask_q <= '0;
      rise_q  <= '0;
      fall_q  <= '0;
    end else begin
      for (int i = 0; i < SEL_REGS; i++) begin
        if (sel_we[i]) sel_q[i] <= wdata_i;
      end
      if (imask_we) imask_q <= wdata_i;
      if (emask_we) emask_q <= wdata_i;
      if (rise_we)  rise_q  <= wdata_i;
      if (fall_we)  fall_q  <= wdata_i;
    end
  end

  // selector words laid end to end give line n its field at n*SEL_W
  assign sel_o      = sel_q;
  assign imask_o    = imask_q;
  assign emask_o    = emask_q;
  assign rise_o     = rise_q;
  assign fall_o     = fall_q;
  assign pend_clr_o = pend_we ? wdata_i : '0;

  always_comb begin
    rdata_o = '0;
    if (addr_i < ADDR_W'(SEL_REGS)) begin
      rdata_o = sel_q[addr_i[SEL_IDX_W-1:0]];
    end else begin
      case (addr_i)
        ADDR_IMASK: rdata_o = imask_q;
        ADDR_EMASK: rdata_o = emask_q;
        ADDR_RISE:  rdata_o = rise_q;
        ADDR_FALL:  rdata_o = fall_q;
        ADDR_PEND:  rdata_o = pend_i;
        default:    rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/eirq_pending.sv
module eirq_pending
  import eirq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] trig_i,
  input  logic [LINES-1:0] imask_i,
  input  logic [LINES-1:0] emask_i,
  input  logic [LINES-1:0] clr_i,
  output logic [LINES-1:0] pend_o,
  output logic [LINES-1:0] evt_o
);
  logic [LINES-1:0] pend_q, pend_d;
  logic [LINES-1:0] evt_q, evt_d;

  // a new trigger outranks a clear landing in the same cycle
  always_comb begin
    pend_d = (pend_q & ~clr_i) | (trig_i & imask_i);
    evt_d  = trig_i & emask_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      evt_q  <= '0;
    end else begin
      pend_q <= pend_d;
      evt_q  <= evt_d;
    end
  end

  assign pend_o = pend_q;
  assign evt_o  = evt_q;
endmodule

// File: rtl/edge_irq_ctrl.sv
module edge_irq_ctrl
  import eirq_pkg::*;
#(
  parameter int NUM_PORTS   = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_PORTS*LINES-1:0] pins_i,
  input  logic                       reg_wr_i,
  input  logic [ADDR_W-1:0]          reg_addr_i,
  input  logic [DATA_W-1:0]          reg_wdata_i,
  output logic [DATA_W-1:0]          reg_rdata_o,
  output logic [LINES-1:0]           irq_o,
  output logic [LINES-1:0]           evt_o
);
  logic [LINES*SEL_W-1:0] sel_w;
  logic [LINES-1:0] imask_w, emask_w, rise_w, fall_w, clr_w, trig_w, pend_w;

  eirq_regfile u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_i       (reg_wr_i),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .pend_i     (pend_w),
    .sel_o      (sel_w),
    .imask_o    (imask_w),
    .emask_o    (emask_w),
    .rise_o     (rise_w),
    .fall_o     (fall_w),
    .pend_clr_o (clr_w),
    .rdata_o    (reg_rdata_o)
  );

  for (genvar n = 0; n < LINES; n++) begin : g_line
    logic [NUM_PORTS-1:0] line_pins;
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      assign line_pins[p] = pins_i[p*LINES + n];
    end
    eirq_line_front #(
      .NUM_PORTS   (NUM_PORTS),
      .SYNC_STAGES (SYNC_STAGES)
    ) u_front (
      .clk       (clk),
      .rst_n     (rst_n),
      .pins_i    (line_pins),
      .sel_i     (sel_w[n*SEL_W +: SEL_W]),
      .rise_en_i (rise_w[n]),
      .fall_en_i (fall_w[n]),
      .trig_o    (trig_w[n])
    );
  end

  eirq_pending u_pend (
    .clk     (clk),
    .rst_n   (rst_n),
    .trig_i  (trig_w),
    .imask_i (imask_w),
    .emask_i (emask_w),
    .clr_i   (clr_w),
    .pend_o  (pend_w),
    .evt_o   (evt_o)
  );

  assign irq_o = pend_w;
endmodule

// File: rtl/eirq_checker.sv
module eirq_checker
  import eirq_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              wr_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [LINES-1:0]  irq_o,
  input logic [LINES-1:0]  evt_o,
  input logic [LINES-1:0]  imask,
  input logic [LINES-1:0]  emask,
  input logic [LINES-1:0]  rise,
  input logic [LINES-1:0]  fall
);
  a_r7_set_needs_imask: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_o & ~$past(irq_o) & ~$past(imask)) == '0));

  a_r6_set_needs_trigger_enable: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_o & ~$past(irq_o) & ~($past(rise) | $past(fall))) == '0));

  a_r8_event_needs_emask: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt_o & ~$past(emask)) == '0));

  a_r9_request_drops_only_on_clear: assert property (@(posedge clk) disable iff (!rst_n)
    ((~irq_o & $past(irq_o)) != '0) |-> $past(wr_i && addr_i == ADDR_PEND));

  a_r10_clear_takes_effect: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_i && addr_i == ADDR_PEND) |-> ((irq_o & $past(wdata_i) & ~$past(imask)) == '0));
endmodule

bind edge_irq_ctrl eirq_checker u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .wr_i    (reg_wr_i),
  .addr_i  (reg_addr_i),
  .wdata_i (reg_wdata_i),
  .irq_o   (irq_o),
  .evt_o   (evt_o),
  .imask   (imask_w),
  .emask   (emask_w),
  .rise    (rise_w),
  .fall    (fall_w)
);

// File: tb/edge_irq_ctrl_test.sv
module edge_irq_ctrl_test;
  localparam int NP = 4;
  localparam int NL = 16;

  logic          clk;
  logic          rst_n;
  logic [NP*NL-1:0] pins;
  logic          wr;
  logic [3:0]    addr;
  logic [15:0]   wdata;
  logic [15:0]   rdata;
  logic [15:0]   irq;
  logic [15:0]   evt;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  edge_irq_ctrl #(.NUM_PORTS(NP)) uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .pins_i      (pins),
    .reg_wr_i    (wr),
    .reg_addr_i  (addr),
    .reg_wdata_i (wdata),
    .reg_rdata_o (rdata),
    .irq_o       (irq),
    .evt_o       (evt)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wreg(input logic [3:0] a, input logic [15:0] d);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0; addr = 4'd0; wdata = '0;
  endtask

  task automatic rreg(input logic [3:0] a, output logic [15:0] d);
    addr = a;
    #1;
    d = rdata;
    @(negedge clk);
    addr = 4'd0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    rst_n = 1'b0; pins = '0; wr = 1'b0; addr = '0; wdata = '0;
    tick(3);
    rst_n = 1'b1;
    tick(1);

    // R1: reset state
    check("R1 irq", irq, 0);
    check("R1 evt", evt, 0);
    for (int a = 0; a <= 8; a++) begin
      rreg(a[3:0], d);
      check($sformatf("R1 reg %0d", a), d, 0);
    end

    // R2 / R4: sweep every line over every port
    wreg(4'd6, 16'hFFFF);
    wreg(4'd4, 16'hFFFF);
    for (int n = 0; n < NL; n++) begin
      for (int p = 0; p < NP; p++) begin
        int q;
        q = (p + 1) % NP;
        pins = '0;
        wreg(4'(n / 4), 16'(p) << (4 * (n % 4)));
        tick(4);
        wreg(4'd8, 16'hFFFF);
        pins[q*NL + n] = 1'b1;
        tick(4);
        check($sformatf("R2 unselected line %0d port %0d", n, q), irq, 0);
        pins[p*NL + n] = 1'b1;
        tick(3);
        check($sformatf("R2 R4 rise line %0d port %0d", n, p), irq, 32'(1) << n);
        wreg(4'd8, 16'hFFFF);
        pins = '0;
        tick(4);
        check($sformatf("R4 fall ignored line %0d port %0d", n, p), irq, 0);
      end
    end
    for (int a = 0; a < 4; a++) wreg(a[3:0], 16'h0000);
    tick(4);
    wreg(4'd8, 16'hFFFF);

    // R3: out-of-range selector
    wreg(4'd0, 16'h0005);
    tick(4);
    for (int p = 0; p < NP; p++) pins[p*NL] = 1'b1;
    tick(4);
    check("R3 invalid port high", irq, 0);
    pins = '0;
    tick(4);
    check("R3 invalid port low", irq, 0);
    wreg(4'd0, 16'h0000);

    // R5: falling only on line 3
    wreg(4'd6, 16'h0000);
    wreg(4'd7, 16'h0008);
    pins[3] = 1'b1;
    tick(4);
    check("R5 rise ignored", irq, 0);
    pins[3] = 1'b0;
    tick(3);
    check("R5 fall sets", irq, 16'h0008);
    wreg(4'd8, 16'hFFFF);

    // R6: both edges, then neither, on line 7
    wreg(4'd6, 16'h0080);
    wreg(4'd7, 16'h0080);
    pins[7] = 1'b1;
    tick(3);
    check("R6 both rise", irq, 16'h0080);
    wreg(4'd8, 16'h0080);
    check("R6 cleared", irq, 0);
    pins[7] = 1'b0;
    tick(3);
    check("R6 both fall", irq, 16'h0080);
    wreg(4'd8, 16'hFFFF);
    wreg(4'd6, 16'h0000);
    wreg(4'd7, 16'h0000);
    pins[7] = 1'b1;
    tick(4);
    check("R6 neither rise", irq, 0);
    pins[7] = 1'b0;
    tick(4);
    check("R6 neither fall", irq, 0);

    // R7 / R8: event without interrupt on line 9
    wreg(4'd6, 16'h0200);
    wreg(4'd4, 16'h0000);
    wreg(4'd5, 16'h0200);
    pins[9] = 1'b1;
    tick(3);
    check("R8 pulse", evt, 16'h0200);
    check("R7 masked", irq, 0);
    tick(1);
    check("R8 single cycle", evt, 0);
    rreg(4'd8, d);
    check("R8 no pending", d, 0);
    pins[9] = 1'b0;
    tick(4);

    // R9 / R10
    wreg(4'd4, 16'hFFFF);
    wreg(4'd5, 16'h0000);
    wreg(4'd6, 16'h0006);
    pins[1] = 1'b1; pins[2] = 1'b1;
    tick(3);
    check("R9 irq", irq, 16'h0006);
    rreg(4'd8, d);
    check("R9 pending read", d, 16'h0006);
    wreg(4'd4, 16'hFFFF);
    check("R10 other address", irq, 16'h0006);
    wreg(4'd8, 16'h0002);
    check("R10 clear one", irq, 16'h0004);
    wreg(4'd8, 16'h0000);
    check("R10 zero write", irq, 16'h0004);
    wreg(4'd8, 16'hFFFB);
    check("R10 other bits", irq, 16'h0004);
    wreg(4'd8, 16'h0004);
    check("R10 clear last", irq, 0);
    pins = '0;
    tick(4);

    // R11: trigger and clear in the same cycle on line 5
    wreg(4'd6, 16'h0020);
    pins[5] = 1'b1;
    tick(3);
    check("R11 setup", irq, 16'h0020);
    pins[5] = 1'b0;
    tick(4);
    pins[5] = 1'b1;
    tick(2);
    wr = 1'b1; addr = 4'd8; wdata = 16'h0020;
    tick(1);
    wr = 1'b0; addr = 4'd0; wdata = '0;
    check("R11 set wins", irq, 16'h0020);
    wreg(4'd8, 16'h0020);
    check("R10 plain clear", irq, 0);
    pins = '0;
    tick(4);

    // R12: readback
    wreg(4'd4, 16'hA5C3);
    wreg(4'd5, 16'h3C5A);
    wreg(4'd6, 16'h1234);
    wreg(4'd7, 16'h8765);
    wreg(4'd2, 16'h3210);
    rreg(4'd4, d); check("R12 imask", d, 16'hA5C3);
    rreg(4'd5, d); check("R12 emask", d, 16'h3C5A);
    rreg(4'd6, d); check("R12 rise", d, 16'h1234);
    rreg(4'd7, d); check("R12 fall", d, 16'h8765);
    rreg(4'd2, d); check("R12 sel", d, 16'h3210);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule